// File: doc/BRIEF.md
# Logarithmic Number Arithmetic Unit

This block is a pipelined arithmetic unit for 16-bit numbers held in logarithmic form. A word carries a sign flag and the base-2 logarithm of the magnitude as a fixed-point value, so the usable range behaves like a short floating-point format. Multiply and divide become an addition or a subtraction of the two logarithms, so no hardware multiplier is needed. Add and subtract take the difference of the two logarithms and use it to index a correction ROM. The entry read there is added to the logarithm of the larger operand. Two ROMs are built: one for operands whose effective signs agree and one for operands whose signs differ. The signs choose the ROM and also set the sign of the result.

Operands enter as a stream of single operations, each with an opcode and two words, under a valid/ready handshake. Results leave in issue order under a second valid/ready handshake. A scalar is simply a one-element stream, so there is no separate scalar path. The pipeline has three register stages: decode and log difference, table read, and final add with saturation. It delivers one result per cycle while the consumer stays ready.

Top module: `lns_alu`

## Requirements
- R1: Word format: bit 15 is the sign and bits 14:0 are a two's-complement base-2 logarithm with 8 fractional bits. A log field of 0x4000 is exact zero whatever the sign bit. The unit always emits zero as 0x4000, with both flags low.
- R2: Opcode 0 multiplies and opcode 1 divides. The result sign is the XOR of the operand signs, and the result log is the sum (multiply) or the difference (dividend minus divisor) of the operand logs.
- R3: When a multiply, divide, add or subtract result log lies above 16383 or below -16383, the result is clamped to 0x3FFF or 0x4001 and carries the operation's sign, and out_ovf is 1 for that result only.
- R4: Multiplying by zero gives zero. Zero divided by a non-zero value gives zero. Any division by zero gives the result sign with log field 0x3FFF, out_dz=1 and out_ovf=0.
- R5: Opcode 2 adds and opcode 3 subtracts. Subtract first inverts the sign of operand b. When one operand is zero the result is the other operand with its effective sign, and when both are zero the result is zero.
- R6: When the effective signs agree, the result log is L + round(256*log2(1+2^-x)), where L is the larger log, d is the absolute log difference, x = 4*floor(d/4)/256, and the sign is the common sign.
- R7: When the effective signs differ, the result log is L + round(256*log2(1-2^-x)) with the same x, except that x = 2/256 when floor(d/4) = 0. The sign is that of the larger-log operand. When d = 0 the result is zero.
- R8: When the absolute log difference d is 4096 or more, add and subtract return the larger-log operand unchanged, with its effective sign.
- R9: An operation accepted at a clock edge appears on the output after the third edge, counting that edge, when out_ready stays high. While out_valid is high and out_ready is low, the output holds steady and in_ready is low.
- R10: During reset and right after it, out_valid is 0. Once the reset has been released through the synchronizer, in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when high together with in_valid |
| in_op | input | 2 | 0 multiply, 1 divide, 2 add, 3 subtract |
| in_a | input | 16 | First operand (dividend, minuend) |
| in_b | input | 16 | Second operand (divisor, subtrahend) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Result word |
| out_ovf | output | 1 | Result was clamped to the log range |
| out_dz | output | 1 | Division by zero |

## Verification
The result only becomes visible three edges after an operation is accepted, so a wrong value held in a stage register shows up on out_data or the flags two or three cycles later, tied to that one operation. A wrong choice of correction ROM leaves multiply and divide untouched. It shows only in add and subtract results: for operands close in magnitude the error is several units of the log, and far apart it shrinks to one or two LSBs. A stall-enable fault shows as a dropped, repeated or reordered result against the scoreboard queue on the first stall.

// File: rtl/lns_pkg.sv
package lns_pkg;

  typedef enum logic [1:0] {
    OP_MUL = 2'd0,
    OP_DIV = 2'd1,
    OP_ADD = 2'd2,
    OP_SUB = 2'd3
  } lns_op_e;

  // how the final stage forms its result
  typedef enum logic [1:0] {
    K_WORD = 2'd0,   // precomputed word, no arithmetic left
    K_DIVZ = 2'd1,   // divisor was zero
    K_MD   = 2'd2,   // saturate a log sum or difference
    K_AS   = 2'd3    // larger log plus table correction, then saturate
  } res_kind_e;

  // correction entry k, in LSBs of the log field: same-sign log2(1+2^-x),
  // opposite-sign log2(1-2^-x); opposite entry 0 taken at half a step
  function automatic int lns_corr_entry(int k, int shift, int frac, bit opp);
    real step;
    real x;
    real g;
    real v;
    step = real'(1 << shift) / real'(1 << frac);
    if (opp && (k == 0)) x = step / 2.0;
    else                 x = real'(k) * step;
    g = $exp(-x * $ln(2.0));
    if (opp) v = $ln(1.0 - g) / $ln(2.0);
    else     v = $ln(1.0 + g) / $ln(2.0);
    v = v * real'(1 << frac);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/lns_rst_sync.sv
module lns_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lns_corr_rom.sv
module lns_corr_rom
  import lns_pkg::*;
#(
  parameter int AW    = 10,
  parameter int SHIFT = 2,
  parameter int FRAC  = 8,
  parameter int CW    = 16,
  parameter int OPP   = 0
) (
  input  logic [AW-1:0] idx,
  output logic [CW-1:0] corr
);

  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    localparam int VAL = lns_corr_entry(k, SHIFT, FRAC, OPP != 0);
    assign tbl[k] = VAL[CW-1:0];
  end

  assign corr = tbl[idx];

endmodule

// File: rtl/lns_decode.sv
module lns_decode
  import lns_pkg::*;
#(
  parameter int LW    = 15,
  parameter int AW    = 10,
  parameter int SHIFT = 2
) (
  input  logic [1:0]           op,
  input  logic [LW:0]          a,
  input  logic [LW:0]          b,
  output res_kind_e            kind,
  output logic                 sgn,
  output logic signed [LW+1:0] sum,
  output logic [LW:0]          word,
  output logic                 same,
  output logic [AW-1:0]        idx
);

  localparam int SW = LW + 2;
  localparam logic [LW-1:0] ZLOG   = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW:0]   ZWORD  = {1'b0, ZLOG};
  localparam logic [SW-1:0] FAR_TH = SW'(1) << (AW + SHIFT);

  lns_op_e            opc;
  logic               za, zb, sbe, a_big, far;
  logic signed [SW-1:0] la, lb, dif;
  logic [SW-1:0]      ad;

  always_comb begin
    opc   = lns_op_e'(op);
    za    = (a[LW-1:0] == ZLOG);
    zb    = (b[LW-1:0] == ZLOG);
    sbe   = b[LW] ^ (opc == OP_SUB);
    la    = {{2{a[LW-1]}}, a[LW-1:0]};
    lb    = {{2{b[LW-1]}}, b[LW-1:0]};
    dif   = la - lb;
    ad    = dif[SW-1] ? SW'(-dif) : dif;
    a_big = !dif[SW-1];
    far   = (ad >= FAR_TH);
    idx   = ad[AW+SHIFT-1:SHIFT];
  end

  always_comb begin
    kind = K_WORD;
    sgn  = 1'b0;
    sum  = '0;
    word = ZWORD;
    same = (a[LW] == sbe);
    if ((opc == OP_MUL) || (opc == OP_DIV)) begin
      sgn = a[LW] ^ b[LW];
      sum = (opc == OP_MUL) ? (la + lb) : dif;
      if ((opc == OP_DIV) && zb) kind = K_DIVZ;
      else if (za || zb)         kind = K_WORD;
      else                       kind = K_MD;
    end else begin
      if (za && zb)                 word = ZWORD;
      else if (za)                  word = {sbe, b[LW-1:0]};
      else if (zb)                  word = a;
      else if (!same && (ad == '0)) word = ZWORD;
      else if (far)                 word = a_big ? a : {sbe, b[LW-1:0]};
      else begin
        kind = K_AS;
        sgn  = a_big ? a[LW] : sbe;
        sum  = a_big ? la : lb;
      end
    end
  end

endmodule

// File: rtl/lns_finish.sv
module lns_finish
  import lns_pkg::*;
#(
  parameter int LW = 15,
  parameter int CW = 16
) (
  input  res_kind_e            kind,
  input  logic                 sgn,
  input  logic signed [LW+1:0] sum,
  input  logic [CW-1:0]        corr,
  input  logic [LW:0]          word,
  output logic [LW:0]          data,
  output logic                 ovf,
  output logic                 dz
);

  localparam int SW = LW + 2;
  localparam logic [LW-1:0] MAXV = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] MINV = {1'b1, {(LW-2){1'b0}}, 1'b1};
  localparam logic signed [SW-1:0] HI = {3'b000, {(LW-1){1'b1}}};
  localparam logic signed [SW-1:0] LO = {3'b111, {(LW-2){1'b0}}, 1'b1};

  logic signed [SW-1:0] cext, tot;

  always_comb begin
    cext = {{(SW-CW){corr[CW-1]}}, corr};
    tot  = (kind == K_AS) ? (sum + cext) : sum;
    data = word;
    ovf  = 1'b0;
    dz   = 1'b0;
    case (kind)
      K_WORD: data = word;
      K_DIVZ: begin
        data = {sgn, MAXV};
        dz   = 1'b1;
      end
      default: begin
        if (tot > HI) begin
          data = {sgn, MAXV};
          ovf  = 1'b1;
        end else if (tot < LO) begin
          data = {sgn, MINV};
          ovf  = 1'b1;
        end else begin
          data = {sgn, tot[LW-1:0]};
        end
      end
    endcase
  end

endmodule

// File: rtl/lns_alu.sv
module lns_alu
  import lns_pkg::*;
#(
  parameter int LOG_W     = 15,
  parameter int FRAC_W    = 8,
  parameter int TBL_AW    = 10,
  parameter int TBL_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [LOG_W:0]   in_a,
  input  logic [LOG_W:0]   in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LOG_W:0]   out_data,
  output logic             out_ovf,
  output logic             out_dz
);

  localparam int W  = LOG_W + 1;
  localparam int SW = LOG_W + 2;
  localparam int CW = LOG_W + 1;

  logic rst_q;
  logic adv;

  lns_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  // stage 1: decode and log difference
  res_kind_e             dec_kind;
  logic                  dec_sgn, dec_same;
  logic signed [SW-1:0]  dec_sum;
  logic [W-1:0]          dec_word;
  logic [TBL_AW-1:0]     dec_idx;

  lns_decode #(.LW(LOG_W), .AW(TBL_AW), .SHIFT(TBL_SHIFT)) u_dec (
    .op   (in_op),
    .a    (in_a),
    .b    (in_b),
    .kind (dec_kind),
    .sgn  (dec_sgn),
    .sum  (dec_sum),
    .word (dec_word),
    .same (dec_same),
    .idx  (dec_idx)
  );

  logic                  s1_vld_q, s1_vld_d;
  res_kind_e             s1_kind_q, s1_kind_d;
  logic                  s1_sgn_q, s1_sgn_d, s1_same_q, s1_same_d;
  logic signed [SW-1:0]  s1_sum_q, s1_sum_d;
  logic [W-1:0]          s1_word_q, s1_word_d;
  logic [TBL_AW-1:0]     s1_idx_q, s1_idx_d;

  // stage 2: correction ROMs, index 0 same sign, index 1 opposite sign
  logic [1:0][CW-1:0]    corr_tab;

  for (genvar g = 0; g < 2; g++) begin : g_rom
    lns_corr_rom #(
      .AW(TBL_AW), .SHIFT(TBL_SHIFT), .FRAC(FRAC_W), .CW(CW), .OPP(g)
    ) u_rom (
      .idx  (s1_idx_q),
      .corr (corr_tab[g])
    );
  end

  logic                  s2_vld_q, s2_vld_d;
  res_kind_e             s2_kind_q, s2_kind_d;
  logic                  s2_sgn_q, s2_sgn_d;
  logic signed [SW-1:0]  s2_sum_q, s2_sum_d;
  logic [W-1:0]          s2_word_q, s2_word_d;
  logic [CW-1:0]         s2_corr_q, s2_corr_d;

  // stage 3: final add and saturation
  logic [W-1:0]          fin_data;
  logic                  fin_ovf, fin_dz;

  lns_finish #(.LW(LOG_W), .CW(CW)) u_fin (
    .kind (s2_kind_q),
    .sgn  (s2_sgn_q),
    .sum  (s2_sum_q),
    .corr (s2_corr_q),
    .word (s2_word_q),
    .data (fin_data),
    .ovf  (fin_ovf),
    .dz   (fin_dz)
  );

  logic                  o_vld_q, o_vld_d;
  logic [W-1:0]          o_data_q, o_data_d;
  logic                  o_ovf_q, o_ovf_d, o_dz_q, o_dz_d;

  assign adv      = !o_vld_q || out_ready;
  assign in_ready = adv && rst_q;

  // next state
  always_comb begin
    s1_vld_d  = in_valid && in_ready;
    s1_kind_d = dec_kind;
    s1_sgn_d  = dec_sgn;
    s1_same_d = dec_same;
    s1_sum_d  = dec_sum;
    s1_word_d = dec_word;
    s1_idx_d  = dec_idx;

    s2_vld_d  = s1_vld_q;
    s2_kind_d = s1_kind_q;
    s2_sgn_d  = s1_sgn_q;
    s2_sum_d  = s1_sum_q;
    s2_word_d = s1_word_q;
    s2_corr_d = s1_same_q ? corr_tab[0] : corr_tab[1];

    o_vld_d   = s2_vld_q;
    o_data_d  = fin_data;
    o_ovf_d   = fin_ovf;
    o_dz_d    = fin_dz;
  end

  // registers, one shared stall enable
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_vld_q  <= 1'b0;
      s1_kind_q <= K_WORD;
      s1_sgn_q  <= 1'b0;
      s1_same_q <= 1'b0;
      s1_sum_q  <= '0;
      s1_word_q <= '0;
      s1_idx_q  <= '0;
      s2_vld_q  <= 1'b0;
      s2_kind_q <= K_WORD;
      s2_sgn_q  <= 1'b0;
      s2_sum_q  <= '0;
      s2_word_q <= '0;
      s2_corr_q <= '0;
      o_vld_q   <= 1'b0;
      o_data_q  <= '0;
      o_ovf_q   <= 1'b0;
      o_dz_q    <= 1'b0;
    end else if (adv) begin
      s1_vld_q  <= s1_vld_d;
      s1_kind_q <= s1_kind_d;
      s1_sgn_q  <= s1_sgn_d;
      s1_same_q <= s1_same_d;
      s1_sum_q  <= s1_sum_d;
      s1_word_q <= s1_word_d;
      s1_idx_q  <= s1_idx_d;
      s2_vld_q  <= s2_vld_d;
      s2_kind_q <= s2_kind_d;
      s2_sgn_q  <= s2_sgn_d;
      s2_sum_q  <= s2_sum_d;
      s2_word_q <= s2_word_d;
      s2_corr_q <= s2_corr_d;
      o_vld_q   <= o_vld_d;
      o_data_q  <= o_data_d;
      o_ovf_q   <= o_ovf_d;
      o_dz_q    <= o_dz_d;
    end
  end

  assign out_valid = o_vld_q;
  assign out_data  = o_data_q;
  assign out_ovf   = o_ovf_q;
  assign out_dz    = o_dz_q;

endmodule

// File: rtl/lns_alu_chk.sv
module lns_alu_chk #(
  parameter int LOG_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LOG_W:0]   out_data,
  input logic             out_ovf,
  input logic             out_dz
);

  localparam logic [LOG_W-1:0] ZLOG = {1'b1, {(LOG_W-1){1'b0}}};
  localparam logic [LOG_W-1:0] MAXV = {1'b0, {(LOG_W-1){1'b1}}};
  localparam logic [LOG_W-1:0] MINV = {1'b1, {(LOG_W-2){1'b0}}, 1'b1};

  // R1: zero leaves normalized and unflagged
  assert_zero_norm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_data[LOG_W-1:0] == ZLOG)) |-> (!out_data[LOG_W] && !out_ovf && !out_dz));

  // R3: a clamped result carries one of the two limit codes
  assert_sat_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (((out_data[LOG_W-1:0] == MAXV) || (out_data[LOG_W-1:0] == MINV)) && !out_dz));

  // R4: division by zero yields the top magnitude code
  assert_divz_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dz) |-> (out_data[LOG_W-1:0] == MAXV));

  // R9: a stalled result stays put
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf) && $stable(out_dz)));

  // R9: no new operation while the output stalls
  assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: three-edge latency without backpressure
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1)) |-> out_valid);

  // R10: nothing valid while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R10: assert (!out_valid);
    end
  end

endmodule

bind lns_alu lns_alu_chk #(.LOG_W(LOG_W)) u_chk (.*);

// File: tb/tb_lns_alu.sv
`timescale 1ns/1ps
module tb_lns_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_op;
  logic [15:0] in_a, in_b;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_data;
  logic        out_ovf, out_dz;

  int checks = 0;
  int bad    = 0;
  bit rr_en  = 1'b0;
  bit done   = 1'b0;
  logic [31:0] rs = 32'h1357_9bdf;

  typedef struct {
    logic [15:0] d;
    logic        ovf;
    logic        dz;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  lns_alu dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ovf(out_ovf), .out_dz(out_dz)
  );

  task automatic nxt(output logic [31:0] v);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    v  = rs;
  endtask

  // correction from the formulas of R6 and R7
  function automatic int tcorr(int k, bit opp);
    real x, g, v;
    x = (opp && k == 0) ? 2.0 / 256.0 : real'(k) * 4.0 / 256.0;
    g = $pow(2.0, -x);
    v = opp ? $ln(1.0 - g) / $ln(2.0) : $ln(1.0 + g) / $ln(2.0);
    v = v * 256.0;
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  function automatic logic [17:0] clamp(logic s, int r);
    if (r > 16383)  return {1'b0, 1'b1, s, 15'h3FFF};
    if (r < -16383) return {1'b0, 1'b1, s, 15'h4001};
    return {1'b0, 1'b0, s, 15'(r)};
  endfunction

  // returns {dz, ovf, data}
  function automatic logic [17:0] model(logic [1:0] op, logic [15:0] a, logic [15:0] b);
    int la, lb, d, ad, lm;
    logic za, zb, sbe, sm;
    la  = int'($signed(a[14:0]));
    lb  = int'($signed(b[14:0]));
    za  = (a[14:0] == 15'h4000);
    zb  = (b[14:0] == 15'h4000);
    if (op < 2) begin
      if (op == 1 && zb) return {1'b1, 1'b0, a[15] ^ b[15], 15'h3FFF};
      if (za || zb)      return {2'b00, 16'h4000};
      return clamp(a[15] ^ b[15], (op == 0) ? la + lb : la - lb);
    end
    sbe = b[15] ^ (op == 3);
    if (za && zb) return {2'b00, 16'h4000};
    if (za)       return {2'b00, sbe, b[14:0]};
    if (zb)       return {2'b00, a};
    d  = la - lb;
    ad = (d < 0) ? -d : d;
    if (a[15] != sbe && ad == 0) return {2'b00, 16'h4000};
    lm = (d >= 0) ? la : lb;
    sm = (d >= 0) ? a[15] : sbe;
    if (ad >= 4096) return {2'b00, sm, 15'(lm)};
    return clamp(sm, lm + tcorr(ad / 4, a[15] != sbe));
  endfunction

  task automatic send(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b, input string tag);
    logic [17:0] m;
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_a     = a;
    in_b     = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    m     = model(op, a, b);
    e.d   = m[15:0];
    e.ovf = m[16];
    e.dz  = m[17];
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    #2;
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected result actual=%h expected=none", out_data);
      end else begin
        e = sbq.pop_front();
        if (out_data !== e.d || out_ovf !== e.ovf || out_dz !== e.dz) begin
          bad++;
          $display("FAIL %s actual=%h ovf=%b dz=%b expected=%h ovf=%b dz=%b",
                   e.tag, out_data, out_ovf, out_dz, e.d, e.ovf, e.dz);
        end
      end
    end
  end

  // random backpressure
  always @(negedge clk) begin
    logic [31:0] v;
    if (rr_en) begin
      nxt(v);
      out_ready = v[3] | v[9];
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r1, r2;
    logic [15:0] rb;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_op     = 2'd0;
    in_a      = 16'h0;
    in_b      = 16'h0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk(out_valid == 1'b0, "R10 valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);

    // R2 multiply and divide
    send(2'd0, 16'h0100, 16'h0080, "R2 mul");
    send(2'd0, 16'h8100, 16'h0080, "R2 mul sign");
    send(2'd1, 16'h0100, 16'h0180, "R2 div");
    send(2'd1, 16'h8100, 16'h8280, "R2 div sign");
    // R3 clamping
    send(2'd0, 16'h3000, 16'h3000, "R3 mul high");
    send(2'd0, 16'h4001, 16'h7FFF, "R3 mul low");
    send(2'd2, 16'h3FFF, 16'h3FFF, "R3 add high");
    // R4 zero operands
    send(2'd0, 16'h0100, 16'h4000, "R4 mul zero");
    send(2'd1, 16'h4000, 16'h0100, "R4 zero div");
    send(2'd1, 16'h8100, 16'h4000, "R4 div by zero");
    send(2'd1, 16'h4000, 16'hC000, "R4 zero div zero");
    // R1 zero encoding
    send(2'd2, 16'hC000, 16'hC000, "R1 neg zero add");
    send(2'd0, 16'hC000, 16'h8200, "R1 neg zero mul");
    // R5 subtract and pass-through
    send(2'd3, 16'h0100, 16'h0100, "R5 x-x");
    send(2'd3, 16'h4000, 16'h0200, "R5 0-b");
    send(2'd2, 16'h0300, 16'h4000, "R5 a+0");
    send(2'd3, 16'h8100, 16'h8100, "R5 -x-(-x)");
    // R6 same sign
    send(2'd2, 16'h0100, 16'h0100, "R6 x+x");
    send(2'd2, 16'h0100, 16'h0000, "R6 ratio 2");
    send(2'd3, 16'h8400, 16'h0123, "R6 neg minus pos");
    // R7 opposite sign
    send(2'd2, 16'h0200, 16'h8100, "R7 add opp");
    send(2'd3, 16'h0100, 16'h0200, "R7 sub neg result");
    send(2'd2, 16'h0101, 16'h8100, "R7 near cancel");
    send(2'd2, 16'h4002, 16'hC001, "R7 clamp low");
    // R8 far apart
    send(2'd2, 16'h1000, 16'h0000, "R8 far same");
    send(2'd2, 16'h0FFF, 16'h0000, "R8 just inside");
    send(2'd2, 16'h8000, 16'h1000, "R8 far opp");
    send(2'd3, 16'h0000, 16'h1000, "R8 far sub");
    idle();
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    // R9 latency with an empty pipe
    send(2'd0, 16'h0010, 16'h0020, "R9 latency op");
    idle();
    #1 chk(out_valid == 1'b0, "R9 latency edge1", out_valid, 0);
    @(negedge clk);
    #1 chk(out_valid == 1'b0, "R9 latency edge2", out_valid, 0);
    @(negedge clk);
    #1 chk(out_valid == 1'b1, "R9 latency edge3", out_valid, 1);
    repeat (3) @(negedge clk);

    // R9 stall
    @(negedge clk);
    out_ready = 1'b0;
    fork
      begin
        for (int i = 0; i < 6; i++)
          send(2'd2, 16'h0100 + 16'(i * 40), 16'h0100, "R9 stall order");
        idle();
      end
      begin
        repeat (8) @(negedge clk);
        #1 chk(in_ready == 1'b0, "R9 ready low in stall", in_ready, 0);
        @(negedge clk);
        out_ready = 1'b1;
      end
    join
    while (sbq.size() != 0) @(negedge clk);

    // random traffic, random backpressure
    rr_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      nxt(r1);
      nxt(r2);
      if (r2[31]) rb = {r2[30], r1[14:0] + {3'b000, r2[11:0]} - 15'h0800};
      else        rb = r2[15:0];
      send(r1[1:0], r1[31:16], rb, "R6/R7 random");
    end
    idle();
    while (sbq.size() != 0) @(negedge clk);
    rr_en = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R9 queue drained", sbq.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule